// File: doc/BRIEF.md
# Dual-Channel Second-Order One-Bit Sigma-Delta Modulator

This block turns two channels of signed 16-bit PCM into two one-bit pulse-density streams. Both streams are produced in the same cycle. The samples arrive already oversampled, at 8 fs, together with a capture pulse. The block keeps the most recent capture for each channel and feeds it into a pair of identical noise-shaping loops. The loops advance once for every second pulse of a master clock enable. That enable runs at 384 fs, so the modulator runs at 192 fs, and each 8 fs sample is reused for 24 modulator steps.

Each channel's loop is a chain of two integrators. Both integrators receive feedback from the previous output bit, which gives a quantization noise transfer of (1 − z⁻¹)². A saturating limiter on each integrator keeps the loop state bounded when the input drives the loop into overload. The one-bit decision is the sign of the second integrator. An output bit of 1 stands for +32767 and a bit of 0 stands for −32767. A low-pass filter downstream recovers the analog waveform from the bit density.

Top module: `sdm2_dac`

## Requirements
- R1: While `rst` is high at a rising clock edge, both output bits, both loop states and both held samples are cleared to zero.
- R2: The modulator advances only on the rising edge at which `mclk_ce` is high for the second time since the previous advance (the count starts from reset). At any other edge both output bits keep their value, and they stay frozen while `mclk_ce` is low.
- R3: A channel's sample is captured from its input bus at an edge where `pcm_vld` is high. It is held until the next such edge. Values on the input buses while `pcm_vld` is low have no effect.
- R4: For a held DC input x (two's complement), the mean of the output mapped to ±1 (bit 1 = +1, bit 0 = −1), taken over 4096 modulator steps after 256 steps of settling, lies within 0.01 of x/32767.
- R5: The left and right channels are modulated in the same steps and independently of each other. Different inputs on the two channels each meet R4 at the same time.
- R6: Both integrators of each loop are saturated to ±4·32767. After a full-scale input (−32768 or +32767) held for 4352 steps, a following DC input again meets R4.
- R7: The output bit is 1 when the updated second integrator is ≥ 0, and 0 otherwise.
- R8: Each step uses fb = +32767 if the previous bit was 1 and −32767 otherwise, and computes i1 ← sat(i1 + x − fb) and i2 ← sat(i2 + i1_new − fb). With x = 0 from reset, the first six bits on each channel are 1, 1, 0, 1, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_ce | input | 1 | Master clock enable at 384 fs |
| pcm_vld | input | 1 | Sample capture pulse at 8 fs |
| pcm_left | input | 16 | Left PCM sample, two's complement |
| pcm_right | input | 16 | Right PCM sample, two's complement |
| pdm_left | output | 1 | Left one-bit stream |
| pdm_right | output | 1 | Right one-bit stream |

## Verification
An output bit is registered at the modulator edge itself, so it can be read at the falling edge that follows. A sample captured at an edge first affects the bit produced at the next modulator edge, one master-enable pulse or more later. The bench keeps its own count of enable pulses to predict which edges advance the modulator. It samples at falling edges and checks that the bits stay still at every other edge. Density checks start only after a 256-step settling window, which is far longer than the one-step input latency and the few steps needed to come out of saturation.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int PCM_W = 16;
    localparam int ACC_W = 22;

    typedef logic signed [PCM_W-1:0] pcm_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t integ1;
        acc_t integ2;
        logic q;
    } loop_st_t;

    function automatic acc_t sat_acc(input acc_t v, input acc_t lim);
        if (v > lim)
            return lim;
        if (v < -lim)
            return -lim;
        return v;
    endfunction

    function automatic acc_t fb_level(input logic q, input acc_t fs);
        return q ? fs : -fs;
    endfunction

endpackage

// File: rtl/sdm_rate_gen.sv
module sdm_rate_gen #(
    parameter int CE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic step
);
    localparam int CNT_W = (CE_DIV > 1) ? $clog2(CE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CE_DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign step = ce && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= '0;
        else if (ce)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdm_hold.sv
module sdm_hold
    import sdm_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld,
    input  logic [NCH-1:0][PCM_W-1:0] din,
    output logic [NCH-1:0][PCM_W-1:0] held
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                held[c] <= '0;
            else if (vld)
                held[c] <= din[c];
        end
    end
endmodule

// File: rtl/sdm_loop.sv
module sdm_loop
    import sdm_pkg::*;
#(
    parameter int LIM_MULT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [PCM_W-1:0] x,
    output logic             q
);
    localparam int   FS_I  = 2 ** (PCM_W - 1) - 1;
    localparam acc_t FS    = acc_t'(FS_I);
    localparam acc_t LIM   = acc_t'(LIM_MULT * FS_I);

    loop_st_t st;
    loop_st_t nx;
    acc_t     fb;
    acc_t     xe;
    acc_t     i1_new;
    acc_t     i2_new;

    always_comb begin
        fb     = fb_level(st.q, FS);
        xe     = acc_t'(pcm_t'(x));
        i1_new = sat_acc(st.integ1 + xe - fb, LIM);
        i2_new = sat_acc(st.integ2 + i1_new - fb, LIM);
        nx.integ1 = i1_new;
        nx.integ2 = i2_new;
        nx.q      = ~i2_new[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (step)
            st <= nx;
    end

    assign q = st.q;
endmodule

// File: rtl/sdm2_dac.sv
module sdm2_dac
    import sdm_pkg::*;
#(
    parameter int LIM_MULT = 4,
    parameter int CE_DIV   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclk_ce,
    input  logic             pcm_vld,
    input  logic [15:0]      pcm_left,
    input  logic [15:0]      pcm_right,
    output logic             pdm_left,
    output logic             pdm_right
);
    localparam int NCH = 2;

    logic                     step;
    logic [NCH-1:0][PCM_W-1:0] din;
    logic [NCH-1:0][PCM_W-1:0] held;
    logic [NCH-1:0]           bits;

    assign din[0] = pcm_left;
    assign din[1] = pcm_right;

    sdm_rate_gen #(.CE_DIV(CE_DIV)) u_rate (
        .clk  (clk),
        .rst  (rst),
        .ce   (mclk_ce),
        .step (step)
    );

    sdm_hold #(.NCH(NCH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .vld  (pcm_vld),
        .din  (din),
        .held (held)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_loop
        sdm_loop #(.LIM_MULT(LIM_MULT)) u_loop (
            .clk  (clk),
            .rst  (rst),
            .step (step),
            .x    (held[c]),
            .q    (bits[c])
        );
    end

    assign pdm_left  = bits[0];
    assign pdm_right = bits[1];
endmodule

// File: rtl/sdm_checkers.sv
module sdm_loop_chk
    import sdm_pkg::*;
#(
    parameter int LIM_MULT = 4
) (
    input logic clk,
    input logic rst,
    input logic step,
    input acc_t i1,
    input acc_t i2,
    input logic q
);
    localparam acc_t LIM = acc_t'(LIM_MULT * (2 ** (PCM_W - 1) - 1));

    p_limit_i1_r6: assert property (@(posedge clk) disable iff (rst)
        (i1 <= LIM) && (i1 >= -LIM));
    p_limit_i2_r6: assert property (@(posedge clk) disable iff (rst)
        (i2 <= LIM) && (i2 >= -LIM));
    p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable({i1, i2, q}));
endmodule

module sdm_top_chk
    import sdm_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 step,
    input logic                 pcm_vld,
    input logic [15:0]          pcm_left,
    input logic [15:0]          pcm_right,
    input logic [1:0][PCM_W-1:0] held,
    input logic                 pdm_left,
    input logic                 pdm_right
);
    p_no_double_step_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
    p_quiet_out_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable({pdm_left, pdm_right}));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !pcm_vld |=> $stable(held));
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        pcm_vld |=> (held[0] == $past(pcm_left)) && (held[1] == $past(pcm_right)));
    p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pdm_left && !pdm_right && held == '0));
endmodule

bind sdm_loop sdm_loop_chk #(.LIM_MULT(LIM_MULT)) u_loop_chk (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .i1   (st.integ1),
    .i2   (st.integ2),
    .q    (st.q)
);

bind sdm2_dac sdm_top_chk u_top_chk (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .pcm_vld   (pcm_vld),
    .pcm_left  (pcm_left),
    .pcm_right (pcm_right),
    .held      (held),
    .pdm_left  (pdm_left),
    .pdm_right (pdm_right)
);

// File: tb/sim_sdm2_dac.sv
`timescale 1ns/1ps
module sim_sdm2_dac;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mclk_ce = 1'b0;
    logic        pcm_vld = 1'b0;
    logic [15:0] pcm_left = '0;
    logic [15:0] pcm_right = '0;
    logic        pdm_left;
    logic        pdm_right;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench view of the enable count (R2): advance on every second enable
    int  ce_cnt = 0;
    int  ones_l;
    int  ones_r;
    int  quiet_err;
    logic prev_l;
    logic prev_r;
    int  clk_no = 0;

    always #10 clk = ~clk;

    sdm2_dac u0 (
        .clk       (clk),
        .rst       (rst),
        .mclk_ce   (mclk_ce),
        .pcm_vld   (pcm_vld),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .pdm_left  (pdm_left),
        .pdm_right (pdm_right)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
        end
    endtask

    // one clock: inputs already driven; returns whether a step happened
    task automatic one_clk(input logic ce, output bit stepped);
        mclk_ce = ce;
        @(posedge clk);
        stepped = 0;
        if (ce) begin
            if (ce_cnt == 1) begin
                stepped = 1;
                ce_cnt = 0;
            end else begin
                ce_cnt = ce_cnt + 1;
            end
        end
        clk_no++;
        @(negedge clk);
        if (!stepped && (pdm_left !== prev_l || pdm_right !== prev_r))
            quiet_err++;
        prev_l = pdm_left;
        prev_r = pdm_right;
    endtask

    // DC run: valid every 48 clocks, garbage on the bus otherwise
    task automatic dc_run(input logic [15:0] vl, input logic [15:0] vr,
                          input bit gap, input string tag);
        int steps;
        int settle;
        bit st;
        real m_l, m_r, e_l, e_r;
        steps = 0;
        settle = 256;
        ones_l = 0;
        ones_r = 0;
        quiet_err = 0;
        while (steps < settle + 4096) begin
            if (clk_no % 48 == 0) begin
                pcm_vld = 1'b1;
                pcm_left = vl;
                pcm_right = vr;
            end else begin
                pcm_vld = 1'b0;
                pcm_left = vl ^ 16'h5a5a;
                pcm_right = ~vr;
            end
            if (steps == 0 && clk_no % 48 != 0) begin
                pcm_vld = 1'b1;
                pcm_left = vl;
                pcm_right = vr;
            end
            one_clk(gap ? ((clk_no % 3) != 2) : 1'b1, st);
            if (st) begin
                if (steps >= settle) begin
                    ones_l += int'(pdm_left);
                    ones_r += int'(pdm_right);
                end
                steps++;
            end
        end
        pcm_vld = 1'b0;
        m_l = (2.0 * ones_l - 4096.0) / 4096.0;
        m_r = (2.0 * ones_r - 4096.0) / 4096.0;
        e_l = $itor($signed(vl)) / 32767.0;
        e_r = $itor($signed(vr)) / 32767.0;
        check((m_l - e_l <= 0.01) && (e_l - m_l <= 0.01), "R4",
              {tag, " left density (R3 R6)"}, $sformatf("%f", m_l), $sformatf("%f", e_l));
        check((m_r - e_r <= 0.01) && (e_r - m_r <= 0.01), "R5",
              {tag, " right density"}, $sformatf("%f", m_r), $sformatf("%f", e_r));
        check(quiet_err == 0, "R2", {tag, " bits move only at steps"},
              $sformatf("%0d", quiet_err), "0");
    endtask

    initial begin
        bit st;
        logic [5:0] seq_l;
        logic [5:0] seq_r;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        prev_l = pdm_left;
        prev_r = pdm_right;
        check(pdm_left == 1'b0 && pdm_right == 1'b0, "R1", "outputs after reset",
              $sformatf("%b%b", pdm_left, pdm_right), "00");

        // R8: zero input straight from reset, exact bit sequence
        n = 0;
        seq_l = '0;
        seq_r = '0;
        quiet_err = 0;
        while (n < 6) begin
            one_clk(1'b1, st);
            if (st) begin
                seq_l[5-n] = pdm_left;
                seq_r[5-n] = pdm_right;
                n++;
            end
        end
        check(seq_l == 6'b110100, "R8", "left first six bits (R1 R7)",
              $sformatf("%b", seq_l), "110100");
        check(seq_r == 6'b110100, "R8", "right first six bits",
              $sformatf("%b", seq_r), "110100");

        // R2: enable low freezes the outputs
        quiet_err = 0;
        for (int k = 0; k < 40; k++) begin
            pcm_left = 16'(k * 777);
            pcm_right = 16'(k * 1313);
            one_clk(1'b0, st);
        end
        check(quiet_err == 0, "R2", "outputs frozen with enable low",
              $sformatf("%0d", quiet_err), "0");

        dc_run(16'sd0,      16'sd0,      1'b0, "zero");
        dc_run(16'sd8192,   -16'sd8192,  1'b0, "quarter");
        dc_run(16'sd16384,  -16'sd24576, 1'b0, "mixed_a");
        dc_run(-16'sd16384, 16'sd24576,  1'b1, "mixed_b_gapped_ce");
        dc_run(16'sd24576,  16'sd4096,   1'b0, "high");
        dc_run(16'h8000,    16'sd32767,  1'b0, "full_scale_R6");
        dc_run(16'sd0,      -16'sd4096,  1'b0, "recovery_R6");
        dc_run(16'sd32767,  16'h8000,    1'b1, "full_scale_swap_R6");
        dc_run(-16'sd8192,  16'sd12000,  1'b0, "recovery2_R6");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R2: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule